// File: doc/BRIEF.md
# Serial Audio Bit-Clock and Frame-Sync Generator

This block is the timing source of a serial audio port running as clock master. It divides a reference clock by an integer to make the bit clock. It then counts bit clocks to make a frame-sync pulse with a repeating period. The frame length in bit clocks comes from the reference frequency, the divider and the wanted sample rate. The pulse width depends on the selected framing: the first half of the frame for I2S, and a single bit clock for the two DSP framings.

A configuration check raises an error when the requested rate cannot be reached. This happens when the frame holds fewer bit clocks than the word length times the channel count, or when the frame is degenerate, or when it is too long for the frame counter. While the error is present, no clocks are generated. In slave mode the pins are not driven and nothing is generated. The reported frame length is then simply the word length times the channel count. Deasserting the enable clears both counters, so the first frame after an enable is a full one.

Top module: `serial_clkgen`

## Requirements
- R1: While `en` is low, and from one clock after it falls, `bclk` and `fsync` are low.
- R2: With effective divider D (`clk_div`, where 0 means 1), `bclk` has a period of D reference cycles. Each period is low for floor(D/2) cycles and then high for the rest. A bit period begins with the low phase.
- R3: In master mode `frame_bits` = floor(floor(`ref_hz`/D)/`rate_hz`). In slave mode it equals `word_len`*`chans`.
- R4: `cfg_err` is high when `fmt`=3. In master mode it is also high when the frame length is below `word_len`*`chans`, below 2, or above 2^FL_W-1, when `rate_hz` is 0, or when `word_len`*`chans` is 0. While `cfg_err` is high, `bclk` and `fsync` stay low.
- R5: In I2S framing (`fmt`=0), `fsync` repeats every `frame_bits` bit periods. It is high during the first floor(`frame_bits`/2) bit periods of each frame.
- R6: In DSP-A (`fmt`=1) and DSP-B (`fmt`=2) framing, `fsync` is high for exactly the first bit period of each frame.
- R7: Every `fsync` transition happens at the same reference edge as a falling `bclk` edge, which is the edge on which transmit data is launched.
- R8: The first sample after enable starts at bit 0 of frame 0, with `fsync` active and `bclk` in its low phase. A disable followed by a re-enable restarts the pattern from that point.
- R9: `drive_en` equals `master` and tells the pads to drive the bit-clock and frame-sync pins.
- R10: In slave mode (`master`=0), `bclk` and `fsync` stay low even when enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Generator enable |
| master | input | 1 | 1 = master mode, 0 = slave mode |
| clk_div | input | DIV_W | Integer bit-clock divider (0 treated as 1) |
| fmt | input | 2 | Framing: 0 I2S, 1 DSP-A, 2 DSP-B, 3 invalid |
| ref_hz | input | REF_W | Reference clock frequency |
| rate_hz | input | REF_W | Wanted sample rate |
| word_len | input | WL_W | Bits per word |
| chans | input | CH_W | Channels per frame |
| bclk | output | 1 | Bit clock |
| fsync | output | 1 | Frame sync, active high |
| drive_en | output | 1 | Output enable for the clock pins |
| cfg_err | output | 1 | Unreachable or invalid configuration |
| frame_bits | output | FL_W | Frame length in bit clocks |

## Verification
The bit-clock and frame-sync waveforms are compared cycle by cycle against a formula model under three configurations:
- I2S with an even divider of 4, which shows the half-frame width.
- DSP-A with an odd divider of 3, which shows the uneven duty split and the single-bit pulse.
- DSP-B with the smallest divider that still gives a registered clock.

The frame-length arithmetic is probed with divider values 0, 1 and 2, which separates the zero-means-one rule from a plain divide. The error check is driven separately by each of its triggers: too little bandwidth, an invalid framing code, a zero rate and counter overflow. This shows that each one alone blocks generation. A disable in the middle of a frame followed by a re-enable shows that the counters restart cleanly and do not resume.

// File: rtl/serial_clkgen.sv
module serial_clkgen #(
  parameter int REF_W = 32,
  parameter int DIV_W = 8,
  parameter int FL_W  = 16,
  parameter int WL_W  = 6,
  parameter int CH_W  = 5
)(
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic             en,
  input  logic             master,
  input  logic [DIV_W-1:0] clk_div,
  input  logic [1:0]       fmt,
  input  logic [REF_W-1:0] ref_hz,
  input  logic [REF_W-1:0] rate_hz,
  input  logic [WL_W-1:0]  word_len,
  input  logic [CH_W-1:0]  chans,
  output logic             bclk,
  output logic             fsync,
  output logic             drive_en,
  output logic             cfg_err,
  output logic [FL_W-1:0]  frame_bits
);
  localparam int NEED_W = WL_W + CH_W;
  localparam logic [1:0] FMT_I2S = 2'd0;
  localparam logic [1:0] FMT_BAD = 2'd3;
  localparam logic [REF_W-1:0] FL_MAX = REF_W'((64'd1 << FL_W) - 64'd1);

  logic [DIV_W-1:0]  div_eff, lo_len, cnt;
  logic [REF_W-1:0]  quot;
  logic [NEED_W-1:0] need;
  logic [FL_W-1:0]   fs_w, fcnt;
  logic              run, go, bit_end;

  assign div_eff = (clk_div == '0) ? DIV_W'(1) : clk_div;
  assign lo_len  = div_eff >> 1;
  assign need    = NEED_W'(word_len) * NEED_W'(chans);
  assign quot    = (rate_hz == '0) ? '0 : (ref_hz / REF_W'(div_eff)) / rate_hz;

  assign cfg_err = (fmt == FMT_BAD) ||
                   (master && (need == '0 || quot < REF_W'(need) ||
                               quot < REF_W'(2) || quot > FL_MAX));

  assign frame_bits = master ? quot[FL_W-1:0] : FL_W'(need);
  assign fs_w       = (fmt == FMT_I2S) ? (frame_bits >> 1) : FL_W'(1);
  assign go         = run && master && !cfg_err;
  assign bit_end    = (cnt >= div_eff - DIV_W'(1));
  assign drive_en   = master;

  assign bclk  = go && ((div_eff == DIV_W'(1)) ? ~clk_ref : (cnt >= lo_len));
  assign fsync = go && (fcnt < fs_w);

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      run  <= 1'b0;
      cnt  <= '0;
      fcnt <= '0;
    end else begin
      run <= en;
      if (!go) begin
        cnt  <= '0;
        fcnt <= '0;
      end else begin
        cnt <= bit_end ? '0 : cnt + DIV_W'(1);
        if (bit_end)
          fcnt <= (fcnt >= frame_bits - FL_W'(1)) ? '0 : fcnt + FL_W'(1);
      end
    end
  end
endmodule

// File: rtl/serial_clkgen_chk.sv
module serial_clkgen_chk #(
  parameter int DIV_W = 8
)(
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             master,
  input logic             run,
  input logic             bclk,
  input logic             fsync,
  input logic             cfg_err,
  input logic [DIV_W-1:0] clk_div,
  input logic [1:0]       fmt
);
  assert_idle_after_disable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!bclk && !fsync));

  assert_err_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (!bclk && !fsync));

  assert_fs_on_falling_bclk_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && clk_div > DIV_W'(1) && $stable(clk_div) && $stable(fmt) &&
     !cfg_err && !$past(cfg_err) && (fsync != $past(fsync)))
    |-> ($past(bclk) && !bclk));

  assert_clean_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(run) && master && !cfg_err && clk_div > DIV_W'(1)) |-> (fsync && !bclk));

  assert_slave_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !master |-> (!bclk && !fsync));
endmodule

bind serial_clkgen serial_clkgen_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk_ref), .rst_n(rst_n), .en(en), .master(master), .run(run),
  .bclk(bclk), .fsync(fsync), .cfg_err(cfg_err), .clk_div(clk_div), .fmt(fmt)
);

// File: tb/serial_clkgen_bench.sv
module serial_clkgen_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        master = 1'b0;
  logic [7:0]  clk_div = 8'd4;
  logic [1:0]  fmt = 2'd0;
  logic [31:0] ref_hz = 32'd12800;
  logic [31:0] rate_hz = 32'd100;
  logic [5:0]  word_len = 6'd16;
  logic [4:0]  chans = 5'd2;
  logic        bclk, fsync, drive_en, cfg_err;
  logic [15:0] frame_bits;

  int n_checks = 0;
  int n_fail = 0;

  serial_clkgen u_serial_clkgen (
    .clk_ref(clk), .rst_n(rst_n), .en(en), .master(master), .clk_div(clk_div),
    .fmt(fmt), .ref_hz(ref_hz), .rate_hz(rate_hz), .word_len(word_len),
    .chans(chans), .bclk(bclk), .fsync(fsync), .drive_en(drive_en),
    .cfg_err(cfg_err), .frame_bits(frame_bits)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic setup(input bit m, input int d, input int f, input int rf,
                       input int rt, input int wl, input int ch);
    master = m; clk_div = 8'(d); fmt = 2'(f); ref_hz = 32'(rf);
    rate_hz = 32'(rt); word_len = 6'(wl); chans = 5'(ch);
    @(negedge clk);
  endtask

  task automatic run_window(input int d, input int f, input int w, input int n,
                            input string fs_req);
    int bad_b = 0, bad_f = 0, bad_e = 0;
    logic pb = 1'b0, pf = 1'b0;
    en = 1'b1;
    @(negedge clk);
    for (int k = 0; k < n; k++) begin
      logic eb, ef;
      eb = ((k % d) >= d / 2);
      ef = (((k / d) % f) < w);
      if (bclk !== eb) bad_b++;
      if (fsync !== ef) bad_f++;
      if (k > 0 && fsync !== pf && !(pb === 1'b1 && bclk === 1'b0)) bad_e++;
      pb = bclk; pf = fsync;
      @(negedge clk);
    end
    chk(bad_b == 0, "R2 bclk waveform mismatches", bad_b, 0);
    chk(bad_f == 0, {fs_req, " fsync waveform mismatches"}, bad_f, 0);
    chk(bad_e == 0, "R7 fsync change not on bclk fall", bad_e, 0);
  endtask

  task automatic idle_window(input int n, input string req);
    int busy = 0;
    for (int k = 0; k < n; k++) begin
      if (bclk !== 1'b0 || fsync !== 1'b0) busy++;
      @(negedge clk);
    end
    chk(busy == 0, req, busy, 0);
  endtask

  task automatic t_reset;
    chk(bclk === 1'b0 && fsync === 1'b0, "R1 outputs low after reset", {bclk, fsync}, 0);
    chk(drive_en === 1'b0, "R9 drive_en low in slave", drive_en, 0);
  endtask

  task automatic t_i2s;
    setup(1, 4, 0, 12800, 100, 16, 2);
    chk(frame_bits == 32, "R3 i2s frame length", frame_bits, 32);
    chk(cfg_err === 1'b0, "R4 no error at exact bandwidth", cfg_err, 0);
    chk(drive_en === 1'b1, "R9 drive_en high in master", drive_en, 1);
    run_window(4, 32, 16, 256, "R5");
    en = 1'b0;
    @(negedge clk);
    idle_window(5, "R1 idle after disable");
  endtask

  task automatic t_dsp_a;
    setup(1, 3, 1, 1440, 10, 16, 2);
    chk(frame_bits == 48, "R3 dsp-a frame length", frame_bits, 48);
    run_window(3, 48, 1, 288, "R6");
    en = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_dsp_b;
    setup(1, 2, 2, 2000, 50, 8, 2);
    chk(frame_bits == 20, "R3 dsp-b frame length", frame_bits, 20);
    run_window(2, 20, 1, 80, "R6");
    en = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_errors;
    setup(1, 4, 0, 12800, 200, 16, 2);
    chk(cfg_err === 1'b1, "R4 bandwidth shortfall flagged", cfg_err, 1);
    en = 1'b1;
    idle_window(40, "R4 no clocks while in error");
    en = 1'b0;
    @(negedge clk);
    setup(1, 4, 3, 12800, 100, 16, 2);
    chk(cfg_err === 1'b1, "R4 framing code 3 flagged", cfg_err, 1);
    setup(1, 4, 0, 12800, 0, 16, 2);
    chk(cfg_err === 1'b1, "R4 zero rate flagged", cfg_err, 1);
    setup(1, 1, 0, 4000000, 1, 16, 2);
    chk(cfg_err === 1'b1, "R4 frame counter overflow flagged", cfg_err, 1);
  endtask

  task automatic t_div_zero;
    setup(1, 0, 0, 6400, 100, 16, 2);
    chk(frame_bits == 64, "R3 divider 0 acts as 1", frame_bits, 64);
    setup(1, 1, 0, 6400, 100, 16, 2);
    chk(frame_bits == 64, "R3 divider 1", frame_bits, 64);
    setup(1, 2, 0, 6400, 100, 16, 2);
    chk(frame_bits == 32, "R3 divider 2", frame_bits, 32);
  endtask

  task automatic t_slave;
    setup(0, 4, 0, 12800, 0, 24, 2);
    chk(frame_bits == 48, "R3 slave frame length", frame_bits, 48);
    chk(cfg_err === 1'b0, "R4 slave ignores rate", cfg_err, 0);
    chk(drive_en === 1'b0, "R9 pins released in slave", drive_en, 0);
    en = 1'b1;
    idle_window(30, "R10 nothing generated in slave");
    en = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_restart;
    setup(1, 4, 0, 12800, 100, 16, 2);
    en = 1'b1;
    repeat (50) @(negedge clk);
    en = 1'b0;
    repeat (3) @(negedge clk);
    run_window(4, 32, 16, 256, "R8");
    en = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    chk(1'b0, "watchdog expired", 1, 0);
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_i2s();
    t_dsp_a();
    t_dsp_b();
    t_errors();
    t_div_zero();
    t_slave();
    t_restart();
    report();
  end
endmodule